// File: doc/BRIEF.md
# Look-Ahead Pipelined First-Order Recursive Filter

This block is a fixed-point first-order recursive low-pass/high-pass section. Its reference behaviour is y[n+1] = a·y[n] + b·x[n]. In the plain form, one multiply and one add must finish inside a single clock period in the feedback path, and that path limits the clock rate. Here the recursion is unrolled one step: y[n+1] = a²·y[n-1] + a·b·x[n-1] + b·x[n]. The feedback loop therefore holds two registers. The loop multiply and the loop add each get a full clock period. The two input terms a·b·x[n-1] + b·x[n] form a two-tap FIR section, which is pipelined ahead of the loop.

Samples arrive one per clock at most, qualified by `in_valid`. Idle cycles neither advance the recursion nor consume the sample bus. The coefficient products a², a·b and b are supplied by the surrounding logic as static Q1.15 values. The bus format is signed Q1.15, so a code c means c/32768. All three products are summed at full precision. The sum is rounded once, half up (add 2^14, then arithmetic shift right by 15), and saturated to 16 bits. The parameter `FIR_EXTRA` adds register stages after the FIR section. The output strobe is delayed by the same amount, and the results do not change.

Top module: `lookahead_iir`

## Requirements
- R1: While `rst_n` is low, `y_out` reads 0 and `out_valid` reads 0, and all filter state is cleared. The first output after reset is then rnd(b·x) of the first sample, with no contribution from earlier samples.
- R2: With coef_a2 = rnd(a·a), coef_ab = rnd(a·b) and coef_b = b, each output stays within 16 LSB of a direct-form model y[n+1] = sat(rnd(a·y[n] + b·x[n])) with y[0] = 0, for |a| ≤ 0.75 and no saturation.
- R3: Output number n+1 equals sat(rnd(a2·y[n-1] + ab·x[n-1] + b·x[n])) exactly. Missing history terms count as 0.
- R4: Each accepted sample produces exactly one `out_valid` pulse, 3 + FIR_EXTRA clock edges after the edge that sampled `in_valid` high.
- R5: On cycles with `in_valid` low, `x_in` is ignored and the state does not advance. A stream with idle gaps yields the same output values as the same stream without gaps, and `y_out` only changes in a cycle where `out_valid` is high.
- R6: A result above 32767 reads 32767, and a result below -32768 reads -32768.
- R7: Rounding is half up on the full-precision sum. With a2 = ab = 0 and b = 16384, inputs 1, -1, 3, -3 give 1, 0, 2, -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| in_valid | input | 1 | Qualifies `x_in` this cycle |
| x_in | input | W | Input sample, signed Q1.15 |
| coef_a2 | input | W | Feedback coefficient a², signed Q1.15 |
| coef_ab | input | W | Delayed-tap coefficient a·b, signed Q1.15 |
| coef_b | input | W | Current-tap coefficient b, signed Q1.15 |
| y_out | output | W | Filtered sample, signed Q1.15 |
| out_valid | output | 1 | Qualifies `y_out`, one pulse per accepted sample |

## Verification
The assertions check the strobe on every cycle. `out_valid` must mirror `in_valid` delayed by the pipeline depth, the number of samples in flight must never exceed that depth, and `y_out` must never move without a strobe. They also check the cleared outputs during reset. Numeric properties depend on sample history, so only the bench's scenarios can show them. These are closeness to the direct-form recursion, exact agreement with the look-ahead form on impulses and gapped streams, the rounding direction and saturation at both rails.

// File: rtl/lookahead_iir_pkg.sv
package lookahead_iir_pkg;
  // Default sample and coefficient width (signed, one integer bit).
  localparam int unsigned SAMPLE_W = 16;
  // Default number of extra register stages behind the FIR section.
  localparam int unsigned FIR_EXTRA_DEF = 0;
  // Registers from the sampling edge to the output: FIR products, FIR sum, loop.
  localparam int unsigned BASE_LAT = 3;
endpackage

// File: rtl/lookahead_iir_fir.sv
module lookahead_iir_fir #(
  parameter int unsigned W = 16,
  localparam int unsigned PW = 2 * W,
  localparam int unsigned SW = 2 * W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  coef_ab,
  input  logic signed [W-1:0]  coef_b,
  output logic                 sum_valid,
  output logic signed [SW-1:0] sum_q
);
  logic signed [W-1:0]  xprev_q, xprev_n;
  logic signed [PW-1:0] pab_q, pab_n, pb_q, pb_n;
  logic                 v1_q, v1_n;
  logic signed [SW-1:0] sum_n;
  logic                 sv_n;

  // Stage 1: products of the delayed and current taps.
  always_comb begin
    xprev_n = xprev_q;
    pab_n   = pab_q;
    pb_n    = pb_q;
    v1_n    = in_valid;
    if (in_valid) begin
      xprev_n = x_in;
      pab_n   = coef_ab * xprev_q;
      pb_n    = coef_b * x_in;
    end
  end

  // Stage 2: full-precision tap sum.
  always_comb begin
    sum_n = sum_q;
    sv_n  = v1_q;
    if (v1_q) begin
      sum_n = SW'(pab_q) + SW'(pb_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xprev_q   <= '0;
      pab_q     <= '0;
      pb_q      <= '0;
      v1_q      <= 1'b0;
      sum_q     <= '0;
      sum_valid <= 1'b0;
    end else begin
      xprev_q   <= xprev_n;
      pab_q     <= pab_n;
      pb_q      <= pb_n;
      v1_q      <= v1_n;
      sum_q     <= sum_n;
      sum_valid <= sv_n;
    end
  end
endmodule

// File: rtl/lookahead_iir_dly.sv
module lookahead_iir_dly #(
  parameter int unsigned WD    = 34,
  parameter int unsigned DEPTH = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WD-1:0] din,
  output logic [WD-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [WD-1:0] stage_q [DEPTH];
      logic [WD-1:0] stage_n [DEPTH];
      always_comb begin
        stage_n[0] = din;
        for (int i = 1; i < DEPTH; i++) stage_n[i] = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
          for (int i = 0; i < DEPTH; i++) stage_q[i] <= stage_n[i];
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/lookahead_iir_loop.sv
module lookahead_iir_loop #(
  parameter int unsigned W = 16,
  localparam int unsigned PW = 2 * W,
  localparam int unsigned SW = 2 * W + 1,
  localparam int unsigned AW = 2 * W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [SW-1:0] ff_sum,
  input  logic signed [W-1:0]  coef_a2,
  output logic signed [W-1:0]  y_q,
  output logic                 yv_q
);
  localparam logic signed [AW-1:0] RND = AW'(1) << (W - 2);
  localparam logic signed [AW-1:0] HI  = AW'((1 << (W - 1)) - 1);
  localparam logic signed [AW-1:0] LO  = -HI - AW'(1);

  // Second loop register: full-precision a2 * y of the previous output.
  logic signed [PW-1:0] m_q, m_n;
  logic signed [W-1:0]  y_n;
  logic signed [AW-1:0] acc, shifted;

  always_comb begin
    acc     = AW'(m_q) + AW'(ff_sum) + RND;
    shifted = acc >>> (W - 1);
    y_n     = y_q;
    m_n     = m_q;
    if (en) begin
      if (shifted > HI)      y_n = HI[W-1:0];
      else if (shifted < LO) y_n = LO[W-1:0];
      else                   y_n = shifted[W-1:0];
      m_n = coef_a2 * y_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q  <= '0;
      m_q  <= '0;
      yv_q <= 1'b0;
    end else begin
      y_q  <= y_n;
      m_q  <= m_n;
      yv_q <= en;
    end
  end
endmodule

// File: rtl/lookahead_iir.sv
module lookahead_iir
  import lookahead_iir_pkg::*;
#(
  parameter int unsigned W         = SAMPLE_W,
  parameter int unsigned FIR_EXTRA = FIR_EXTRA_DEF,
  localparam int unsigned SW  = 2 * W + 1,
  localparam int unsigned LAT = BASE_LAT + FIR_EXTRA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] coef_a2,
  input  logic signed [W-1:0] coef_ab,
  input  logic signed [W-1:0] coef_b,
  output logic signed [W-1:0] y_out,
  output logic                out_valid
);
  logic                 fir_v;
  logic signed [SW-1:0] fir_sum;
  logic [SW:0]          dly_in, dly_out;
  logic                 loop_en;
  logic signed [SW-1:0] loop_sum;

  lookahead_iir_fir #(.W(W)) u_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
    .coef_ab(coef_ab), .coef_b(coef_b),
    .sum_valid(fir_v), .sum_q(fir_sum)
  );

  assign dly_in = {fir_v, fir_sum};

  lookahead_iir_dly #(.WD(SW + 1), .DEPTH(FIR_EXTRA)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(dly_in), .dout(dly_out)
  );

  assign loop_en  = dly_out[SW];
  assign loop_sum = dly_out[SW-1:0];

  lookahead_iir_loop #(.W(W)) u_loop (
    .clk(clk), .rst_n(rst_n), .en(loop_en), .ff_sum(loop_sum),
    .coef_a2(coef_a2), .y_q(y_out), .yv_q(out_valid)
  );
endmodule

// File: rtl/lookahead_iir_chk.sv
module lookahead_iir_chk #(
  parameter int unsigned W   = 16,
  parameter int unsigned LAT = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic signed [W-1:0] y_out,
  input logic                out_valid
);
  logic [LAT-1:0] hist;
  int unsigned    pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      pend <= 0;
    end else begin
      hist <= {hist[LAT-2:0], in_valid};
      pend <= pend + 32'(in_valid) - 32'(out_valid);
    end
  end

  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[LAT-1]);

  // R4
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend <= LAT) && (!out_valid || pend > 0));

  // R5
  output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_out != $past(y_out)) |-> out_valid);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (y_out == '0 && !out_valid);
    end
  end
endmodule

bind lookahead_iir lookahead_iir_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .y_out(y_out), .out_valid(out_valid)
);

// File: tb/lookahead_iir_tb.sv
module lookahead_iir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TOL = 16;
  localparam int NS = 40;
  // a, b, step amplitude, settled output (Q1.15 codes)
  localparam int TBL [4][4] = '{
    '{16384,  8192,  16384,  8192},
    '{24576,  8192,  16384, 16384},
    '{-16384, 16384, -16384, -5461},
    '{0,      16384,  16384,  8192}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [15:0] x_in, coef_a2, coef_ab, coef_b, y_out;
  logic out_valid;

  int errors = 0, checks = 0;
  int cap [0:1023];
  int ncap = 0;
  int expd [0:63];
  int md;
  int ca2, cab, cb, lym1, ly0, lxp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lookahead_iir u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
    .coef_a2(coef_a2), .coef_ab(coef_ab), .coef_b(coef_b),
    .y_out(y_out), .out_valid(out_valid)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && ncap < 1024) begin
      cap[ncap] = int'(y_out);
      ncap = ncap + 1;
    end
  end

  function automatic int rs(longint acc);
    longint r;
    r = (acc + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(string req, string what, int act, int exp, int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_coef(int a2, int ab, int b);
    ca2 = a2; cab = ab; cb = b;
    coef_a2 = 16'(a2); coef_ab = 16'(ab); coef_b = 16'(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; x_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lym1 = 0; ly0 = 0; lxp = 0;
  endtask

  // Drives one sample and returns the look-ahead expected output.
  task automatic push(int x, output int la);
    @(negedge clk);
    in_valid = 1'b1;
    x_in = 16'(x);
    la = rs(longint'(ca2) * lym1 + longint'(cab) * lxp + longint'(cb) * x);
    lym1 = ly0; ly0 = la; lxp = x;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      x_in = 16'sh7fff;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int la, base, a, b, x, hold;
    rst_n = 1'b0; in_valid = 1'b0; x_in = '0;
    set_coef(0, 0, 0);
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "y_out in reset", int'(y_out), 0, 0);
    chk("R1", "out_valid in reset", int'(out_valid), 0, 0);

    // R2 table of step responses against the direct form
    for (int e = 0; e < 4; e++) begin
      a = TBL[e][0]; b = TBL[e][1]; x = TBL[e][2];
      do_reset();
      set_coef(rs(longint'(a) * a), rs(longint'(a) * b), b);
      md = 0;
      base = ncap;
      for (int i = 0; i < NS; i++) begin
        push(x, la);
        md = rs(longint'(a) * md + longint'(b) * x);
        expd[i] = md;
      end
      idle(8);
      chk("R4", "outputs per step run", ncap - base, NS, 0);
      for (int i = 0; i < NS; i++) chk("R2", "step sample", cap[base + i], expd[i], TOL);
      chk("R2", "settled value", cap[base + NS - 1], TBL[e][3], TOL);
    end

    // R3 impulse, a=0.5, b=0.5: exact halving
    do_reset();
    set_coef(8192, 8192, 16384);
    base = ncap;
    push(16384, la);
    for (int i = 0; i < 5; i++) push(0, la);
    idle(6);
    for (int i = 0; i < 5; i++) chk("R3", "impulse tap", cap[base + i], 8192 >> i, 0);

    // R4 latency of a single sample
    do_reset();
    push(100, la);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk("R4", "out_valid timing", int'(out_valid), (i == 3) ? 1 : 0, 0);
    end

    // R5 gapped stream with junk on idle cycles vs look-ahead model
    do_reset();
    set_coef(18432, 6144, 8192);
    base = ncap;
    for (int i = 0; i < 12; i++) begin
      push((i % 3 == 0) ? 20000 : -7000 + i * 900, la);
      expd[i] = la;
      if (i % 2 == 1) idle(i % 4 + 1);
    end
    idle(8);
    hold = int'(y_out);
    chk("R5", "outputs with gaps", ncap - base, 12, 0);
    for (int i = 0; i < 12; i++) chk("R5", "gapped sample", cap[base + i], expd[i], 0);
    idle(5);
    chk("R5", "hold while idle", int'(y_out), hold, 0);

    // R6 saturation at both rails
    do_reset();
    set_coef(0, 32767, 32767);
    base = ncap;
    push(32767, la); push(32767, la); push(-32768, la); push(-32768, la);
    idle(6);
    chk("R6", "near top", cap[base], 32766, 0);
    chk("R6", "clip high", cap[base + 1], 32767, 0);
    chk("R6", "mixed", cap[base + 2], -1, 0);
    chk("R6", "clip low", cap[base + 3], -32768, 0);

    // R7 rounding half up
    do_reset();
    set_coef(0, 0, 16384);
    base = ncap;
    push(1, la); push(-1, la); push(3, la); push(-3, la);
    idle(6);
    chk("R7", "round +0.5", cap[base], 1, 0);
    chk("R7", "round -0.5", cap[base + 1], 0, 0);
    chk("R7", "round +1.5", cap[base + 2], 2, 0);
    chk("R7", "round -1.5", cap[base + 3], -1, 0);

    // R1 reset in mid-stream clears state
    do_reset();
    set_coef(8192, 8192, 16384);
    for (int i = 0; i < 4; i++) push(30000, la);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", "y_out after async reset", int'(y_out), 0, 0);
    chk("R1", "out_valid after async reset", int'(out_valid), 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    lym1 = 0; ly0 = 0; lxp = 0;
    base = ncap;
    push(16384, la); push(0, la);
    idle(6);
    chk("R1", "first output after reset", cap[base], 8192, 0);
    chk("R1", "second output after reset", cap[base + 1], 4096, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule